// File: doc/BRIEF.md
# SPI Master with Sticky Status Flags

This block is a bus-attached SPI master. Software programs a control word and a clock divider. Writing a word to the data register while the engine is idle starts a serial exchange on `sck`, `mosi` and `miso`. The exchange is 8 or 16 bits long, with selectable clock polarity, clock phase and bit order. When the last bit has been sampled, the received word is latched into a read buffer and a completion flag is raised.

Errors are held in sticky flags in the status register:

- A data write that arrives while the engine is shifting is discarded and reported as a collision.
- A transfer that ends while the previous completion is still uncollected is reported as an overrun.
- An abort flag and a fault flag can only be raised by test inputs, because the block never acts as a slave.

Most flags clear through a two-step sequence. Software first reads the status register, and this arms a clear for each flag that was set at that moment. A later data access, or for the fault flag a control write, then clears only the armed flags. A flag raised after the status read survives the sequence. A single level interrupt reports any pending flag when it is enabled.

Top module: `spi_ms_top`

## Requirements
- R1: Register map by `bus_addr`: 0 is control, 1 is status, 2 is data, 3 is divider. After reset, control, status and data read 0 and the divider reads 8. Reads return the value held before the clock edge that registers the access.
- R2: Control bits, captured at transfer start:
  - bit 0 selects a 16-bit word (otherwise 8-bit);
  - bit 1 is the clock polarity;
  - bit 2 is the clock phase;
  - bit 3 selects least-significant-bit first (otherwise most-significant first);
  - bit 4 is the interrupt enable.
- R3: Clock waveform and data timing:
  - While idle, `sck` equals control bit 1.
  - Each bit lasts D clocks, where D is the divider value: D/2 clocks at the idle level, then D/2 clocks at the opposite level.
  - Phase 0 presents `mosi` from the start of the bit and samples `miso` on the first edge.
  - Phase 1 changes `mosi` on the first edge and samples `miso` on the second edge.
- R4: A data write while idle starts a transfer. The completion flag (status bit 7) is set N·D+1 clocks after the write edge, where N is the word length. If no overrun occurs, the received word is latched into the read buffer at the same time. In 8-bit mode, bits 15:8 of a data read are 0.
- R5: Reading the status register leaves the completion flag set. It is cleared only by a status read made while it was set, followed by a data read or data write.
- R6: A data write during a transfer sets the collision flag (status bit 6). It leaves the transfer's `mosi` data and its length unchanged.
- R7: A completion while the completion flag is still set sets the overrun flag (status bit 5). The read buffer then keeps the earlier word.
- R8: The overrun and collision flags clear by the same status-read-then-data-access sequence as the completion flag.
- R9: `tst_abort` sets status bit 3. Any status read clears it.
- R10: `tst_modef` sets status bit 4. It clears only by a status read made while it was set, followed by a control write. A data access does not clear it.
- R11: Divider writes below 8 store 8. Odd values are rounded down to even.
- R12: `irq` is high exactly when the interrupt enable is set and any of status bits 3 to 7 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Level interrupt |
| tst_abort | input | 1 | Test input that raises the abort flag |
| tst_modef | input | 1 | Test input that raises the fault flag |

## Verification
Transfers are run with asymmetric transmit words and slave bit patterns, so that a swapped bit order or a wrong sampling edge shows up as a different word. They cover the most-significant-first, 8-bit, phase-0 case and the 16-bit, least-significant-first, phase-1, inverted-polarity case. Flag clearing is tried in three orders:

- a status read alone;
- a data read without a preceding status read;
- the full two-step sequence.

These show that the clear depends on the arming read. A collision write in mid-transfer and two back-to-back uncollected transfers separate collision from overrun and show which word the buffer keeps. A behavioural model of the flags is compared with `irq` and the idle `sck` level on every clock, which catches flags that set or clear one cycle off.

// File: rtl/spi_ms_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the SPI master: register addresses, control layout
// and status bit positions. Assumes a 2-bit register address.
package spi_ms_pkg;
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;
    localparam logic [1:0] A_DIV  = 2'd3;

    localparam int S_ABORT = 3;
    localparam int S_MODEF = 4;
    localparam int S_OVR   = 5;
    localparam int S_WCOL  = 6;
    localparam int S_DONE  = 7;

    localparam int MIN_DIV = 8;

    typedef struct packed {
        logic irq_en;   // bit 4
        logic lsb;      // bit 3
        logic cpha;     // bit 2
        logic cpol;     // bit 1
        logic wide;     // bit 0
    } ctl_t;
endpackage

// File: rtl/spi_ms_regs.sv
`timescale 1ns/1ps
// Control and divider registers. The divider is kept even and at least
// MIN_DIV. Assumes DIVW <= DW and DIVW >= 4.
module spi_ms_regs
    import spi_ms_pkg::*;
#(
    parameter int DW   = 16,
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctl_we,
    input  logic            div_we,
    input  logic [DW-1:0]   wdata,
    output ctl_t            ctl,
    output logic [DIVW-1:0] div
);
    localparam logic [DIVW-1:0] DIV_FLOOR = DIVW'(MIN_DIV);

    logic [DIVW-1:0] div_in;
    assign div_in = wdata[DIVW-1:0];

    // Register updates from bus writes; the divider write is clamped and evened.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
            div <= DIV_FLOOR;
        end else begin
            if (ctl_we) ctl <= ctl_t'(wdata[4:0]);
            if (div_we) div <= (div_in < DIV_FLOOR) ? DIV_FLOOR : {div_in[DIVW-1:1], 1'b0};
        end
    end
endmodule

// File: rtl/spi_ms_engine.sv
`timescale 1ns/1ps
// Shift engine and clock generator. A start while idle captures the word,
// the configuration and the divider. Each bit is two half periods of div/2
// clocks: the first at the idle level, the second inverted. 'complete' is a
// one-cycle pulse after the final sample. Assumes div is even and >= 8.
module spi_ms_engine
    import spi_ms_pkg::*;
#(
    parameter int DW   = 16,
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [DW-1:0]   tx_word,
    input  ctl_t            cfg,
    input  logic [DIVW-1:0] div,
    input  logic            idle_cpol,
    input  logic            miso,
    output logic            busy,
    output logic            complete,
    output logic [DW-1:0]   rx_word,
    output logic            sck,
    output logic            mosi
);
    localparam int IW = $clog2(DW);
    localparam int HW = DIVW - 1;

    ctl_t          cfg_q;
    logic [DW-1:0] tx_q;
    logic [HW-1:0] half_len, hcnt;
    logic [IW-1:0] idx, pos_now, pos_next, pos_first, last_q;
    logic          half;

    // Wire position to word bit index, from bit order and word length.
    function automatic logic [IW-1:0] map_pos(input logic [IW-1:0] i, input logic wide,
                                              input logic lsb);
        logic [IW-1:0] top;
        top = wide ? IW'(DW - 1) : IW'(DW / 2 - 1);
        return lsb ? i : top - i;
    endfunction

    assign last_q    = cfg_q.wide ? IW'(DW - 1) : IW'(DW / 2 - 1);
    assign pos_now   = map_pos(idx, cfg_q.wide, cfg_q.lsb);
    assign pos_next  = map_pos(idx + 1'b1, cfg_q.wide, cfg_q.lsb);
    assign pos_first = map_pos('0, cfg.wide, cfg.lsb);

    assign sck  = busy ? (cfg_q.cpol ^ half) : idle_cpol;
    assign mosi = mosi_q;

    logic mosi_q;

    // Bit sequencing: half-period timing, sampling, output update, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            complete <= 1'b0;
            half     <= 1'b0;
            hcnt     <= '0;
            half_len <= '0;
            idx      <= '0;
            tx_q     <= '0;
            rx_word  <= '0;
            cfg_q    <= '0;
            mosi_q   <= 1'b0;
        end else begin
            complete <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy     <= 1'b1;
                    half     <= 1'b0;
                    hcnt     <= '0;
                    idx      <= '0;
                    tx_q     <= tx_word;
                    cfg_q    <= cfg;
                    half_len <= div[DIVW-1:1];
                    rx_word  <= '0;
                    if (!cfg.cpha) mosi_q <= tx_word[pos_first];
                end
            end else if (hcnt == half_len - 1'b1) begin
                hcnt <= '0;
                if (!half) begin
                    half <= 1'b1;
                    if (!cfg_q.cpha) rx_word[pos_now] <= miso;
                    else             mosi_q <= tx_q[pos_now];
                end else begin
                    half <= 1'b0;
                    if (cfg_q.cpha) rx_word[pos_now] <= miso;
                    if (idx == last_q) begin
                        busy     <= 1'b0;
                        complete <= 1'b1;
                    end else begin
                        idx <= idx + 1'b1;
                        if (!cfg_q.cpha) mosi_q <= tx_q[pos_next];
                    end
                end
            end else begin
                hcnt <= hcnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/spi_ms_flags.sv
`timescale 1ns/1ps
// Sticky status flags with armed clearing. A status read snapshots which
// flags are set. A later data access clears the armed done, overrun and
// collision flags; a later control write clears the armed fault flag.
// A status read alone clears the abort flag. Sets win over clears.
module spi_ms_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic st_rd,
    input  logic data_acc,
    input  logic data_wr,
    input  logic ctl_wr,
    input  logic busy,
    input  logic complete,
    input  logic tst_abort,
    input  logic tst_modef,
    output logic done,
    output logic ovr,
    output logic wcol,
    output logic modef,
    output logic abort
);
    logic arm_done, arm_ovr, arm_wcol, arm_mf;

    // Flag and arm update: clears first, then sets, so a set in the same cycle wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {done, ovr, wcol, modef, abort}       <= '0;
            {arm_done, arm_ovr, arm_wcol, arm_mf} <= '0;
        end else begin
            if (st_rd) begin
                arm_done <= done;
                arm_ovr  <= ovr;
                arm_wcol <= wcol;
                arm_mf   <= modef;
                abort    <= 1'b0;
            end
            if (data_acc) begin
                if (arm_done) done <= 1'b0;
                if (arm_ovr)  ovr  <= 1'b0;
                if (arm_wcol) wcol <= 1'b0;
                {arm_done, arm_ovr, arm_wcol} <= '0;
            end
            if (ctl_wr) begin
                if (arm_mf) modef <= 1'b0;
                arm_mf <= 1'b0;
            end
            if (complete) begin
                done <= 1'b1;
                if (done) ovr <= 1'b1;
            end
            if (data_wr && busy) wcol  <= 1'b1;
            if (tst_abort)       abort <= 1'b1;
            if (tst_modef)       modef <= 1'b1;
        end
    end
endmodule

// File: rtl/spi_ms_top.sv
`timescale 1ns/1ps
// SPI master top: bus decode, read mux, received-word buffer and interrupt.
// Assumes one bus access per cycle; reads have their side effect at the edge.
module spi_ms_top
    import spi_ms_pkg::*;
#(
    parameter int DW   = 16,
    parameter int DIVW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          sck,
    output logic          mosi,
    input  logic          miso,
    output logic          irq,
    input  logic          tst_abort,
    input  logic          tst_modef
);
    ctl_t            ctl;
    logic [DIVW-1:0] div;
    logic            busy, complete;
    logic [DW-1:0]   rx_word, rx_buf;
    logic            done, ovr, wcol, modef, abort;
    logic            st_rd, data_acc, data_wr, ctl_wr, div_wr;

    assign st_rd    = bus_sel && !bus_wr && (bus_addr == A_STAT);
    assign data_acc = bus_sel && (bus_addr == A_DATA);
    assign data_wr  = data_acc && bus_wr;
    assign ctl_wr   = bus_sel && bus_wr && (bus_addr == A_CTRL);
    assign div_wr   = bus_sel && bus_wr && (bus_addr == A_DIV);

    spi_ms_regs #(.DW(DW), .DIVW(DIVW)) u_regs (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_wr), .div_we(div_wr),
        .wdata(bus_wdata), .ctl(ctl), .div(div)
    );

    spi_ms_engine #(.DW(DW), .DIVW(DIVW)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(data_wr), .tx_word(bus_wdata),
        .cfg(ctl), .div(div), .idle_cpol(ctl.cpol), .miso(miso),
        .busy(busy), .complete(complete), .rx_word(rx_word),
        .sck(sck), .mosi(mosi)
    );

    spi_ms_flags u_flags (
        .clk(clk), .rst_n(rst_n), .st_rd(st_rd), .data_acc(data_acc),
        .data_wr(data_wr), .ctl_wr(ctl_wr), .busy(busy), .complete(complete),
        .tst_abort(tst_abort), .tst_modef(tst_modef),
        .done(done), .ovr(ovr), .wcol(wcol), .modef(modef), .abort(abort)
    );

    // Received-word buffer: loads at completion unless the previous word is uncollected.
    always_ff @(posedge clk) begin
        if (!rst_n)                 rx_buf <= '0;
        else if (complete && !done) rx_buf <= rx_word;
    end

    // Read data selection by register address.
    always_comb begin
        unique case (bus_addr)
            A_CTRL:  bus_rdata = DW'(ctl);
            A_STAT:  bus_rdata = DW'({done, wcol, ovr, modef, abort, 3'b000});
            A_DATA:  bus_rdata = rx_buf;
            default: bus_rdata = DW'(div);
        endcase
    end

    assign irq = ctl.irq_en && (done || ovr || wcol || modef || abort);
endmodule

// File: rtl/spi_ms_chk.sv
`timescale 1ns/1ps
// Property checker for spi_ms_top, attached by bind.
// Assumes a synchronous active-low reset.
module spi_ms_chk #(
    parameter int DIVW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            complete,
    input logic            done,
    input logic            ovr,
    input logic            wcol,
    input logic            data_wr,
    input logic            data_acc,
    input logic [DIVW-1:0] div
);
    // R4
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !busy) |=> busy);
    // R4
    done_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        complete |=> done);
    // R5
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !data_acc) |=> done);
    // R6
    wcol_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && busy) |=> (wcol && busy));
    // R7
    ovr_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (complete && done) |=> ovr);
    // R11
    div_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div >= DIVW'(8)) && !div[0]);
endmodule

bind spi_ms_top spi_ms_chk #(.DIVW(DIVW)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .complete(complete),
    .done(done), .ovr(ovr), .wcol(wcol), .data_wr(data_wr),
    .data_acc(data_acc), .div(div)
);

// File: tb/spi_ms_top_test.sv
`timescale 1ns/1ps
module spi_ms_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        sck, mosi, irq;
    logic        miso = 1'b0;
    logic        tst_abort = 1'b0, tst_modef = 1'b0;

    int total = 0, bad = 0;
    bit finished = 0;

    spi_ms_top uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck(sck), .mosi(mosi), .miso(miso), .irq(irq),
        .tst_abort(tst_abort), .tst_modef(tst_modef)
    );

    always #2 clk = ~clk;   // 250 MHz

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural flag model ----------------
    int m_rem = 0; bit m_pend = 0;
    bit m_done, m_ovr, m_wcol, m_mf, m_ab;
    bit a_done, a_ovr, a_wcol, a_mf;
    int m_ctl = 0, m_div = 8;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rem = 0; m_pend = 0;
            {m_done, m_ovr, m_wcol, m_mf, m_ab} = '0;
            {a_done, a_ovr, a_wcol, a_mf} = '0;
            m_ctl = 0; m_div = 8;
        end else begin
            bit od, cmp, bz;
            od = m_done; cmp = m_pend; m_pend = 0;
            bz = (m_rem > 0);
            if (m_rem > 0) begin m_rem--; if (m_rem == 0) m_pend = 1; end
            if (bus_sel && !bus_wr && bus_addr == 1) begin
                a_done = m_done; a_ovr = m_ovr; a_wcol = m_wcol; a_mf = m_mf; m_ab = 0;
            end
            if (bus_sel && bus_addr == 2) begin
                if (a_done) m_done = 0;
                if (a_ovr)  m_ovr = 0;
                if (a_wcol) m_wcol = 0;
                a_done = 0; a_ovr = 0; a_wcol = 0;
            end
            if (bus_sel && bus_wr && bus_addr == 0) begin
                if (a_mf) m_mf = 0;
                a_mf = 0;
                m_ctl = int'(bus_wdata[4:0]);
            end
            if (bus_sel && bus_wr && bus_addr == 3)
                m_div = (bus_wdata[7:0] < 8) ? 8 : int'(bus_wdata[7:0]) & ~1;
            if (bus_sel && bus_wr && bus_addr == 2) begin
                if (bz) m_wcol = 1;
                else    m_rem = ((m_ctl & 1) ? 16 : 8) * m_div;
            end
            if (cmp) begin
                if (od) m_ovr = 1;
                m_done = 1;
            end
            if (tst_abort) m_ab = 1;
            if (tst_modef) m_mf = 1;
        end
    end

    // Per-clock comparison of irq and idle clock level (R12, R3).
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R12 irq level", irq,
                ((m_ctl >> 4) & 1) && (m_done | m_ovr | m_wcol | m_mf | m_ab));
            if (m_rem == 0) chk("R3 idle sck", sck, (m_ctl >> 1) & 1);
        end
    end

    // ---------------- bench SPI slave ----------------
    logic [15:0] s_pat, c_pat;
    int s_k, c_k;
    bit s_act = 0;

    always @(posedge sck or negedge sck) begin
        if (s_act) begin
            bit lead, ph;
            lead = (sck != 1'((m_ctl >> 1) & 1));
            ph   = 1'((m_ctl >> 2) & 1);
            if (!ph) begin
                if (lead) begin if (c_k < 16) c_pat[c_k] = mosi; c_k++; end
                else begin s_k++; if (s_k < 16) miso = s_pat[s_k]; end
            end else begin
                if (lead) begin if (s_k < 16) miso = s_pat[s_k]; s_k++; end
                else begin if (c_k < 16) c_pat[c_k] = mosi; c_k++; end
            end
        end
    end

    // Word <-> wire order conversion (its own inverse).
    function automatic logic [15:0] reorder(input logic [15:0] v, input int nb, input bit lsb);
        logic [15:0] r = '0;
        for (int k = 0; k < nb; k++) r[k] = lsb ? v[k] : v[nb-1-k];
        return r;
    endfunction

    // ---------------- bus tasks ----------------
    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic launch(input logic [15:0] tx, input logic [15:0] pat);
        s_pat = pat; s_k = 0; c_k = 0; c_pat = '0;
        miso = ((m_ctl >> 2) & 1) ? 1'b0 : pat[0];
        s_act = 1;
        wr(2, tx);
    endtask

    task automatic settle();
        repeat (((m_ctl & 1) ? 16 : 8) * m_div + 3) @(negedge clk);
        s_act = 0;
    endtask

    logic [15:0] v;
    int nb; bit lsb;

    initial begin
        #(4 * 150000);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset values and map
        rd(0, v); chk("R1 ctrl reset", v, 16'h0000);
        rd(1, v); chk("R1 status reset", v, 16'h0000);
        rd(2, v); chk("R1 data reset", v, 16'h0000);
        rd(3, v); chk("R1 divider reset", v, 16'h0008);
        chk("R1 irq reset", irq, 0);

        // Basic 8-bit, MSB-first, phase 0, interrupt enabled (R2, R3, R4)
        wr(0, 16'h0010);
        rd(0, v); chk("R2 ctrl readback", v, 16'h0010);
        launch(16'h00A5, 16'h003C);
        settle();
        chk("R3 mosi wire order msb", c_pat[7:0], reorder(16'h00A5, 8, 0) & 16'hFF);
        chk("R3 mosi bit count", c_k, 8);
        rd(1, v); chk("R4 done set", v, 16'h0080);
        chk("R12 irq with done", irq, 1);
        rd(1, v); chk("R5 status read alone keeps done", v, 16'h0080);
        rd(2, v); chk("R4 rx word msb", v, reorder(16'h003C, 8, 0));
        rd(1, v); chk("R5 done cleared by sequence", v, 16'h0000);

        // Data read without arming read does not clear (R5)
        launch(16'h0081, 16'h00F0);
        settle();
        rd(2, v); chk("R4 rx second word", v, reorder(16'h00F0, 8, 0));
        rd(1, v); chk("R5 data read unarmed keeps done", v, 16'h0080);
        rd(2, v);
        rd(1, v); chk("R5 done cleared after arm", v, 16'h0000);

        // Collision (R6) and its clearing (R8)
        launch(16'h005A, 16'h0055);
        repeat (6) @(negedge clk);
        wr(2, 16'h00FF);
        settle();
        chk("R6 mosi undisturbed", c_pat[7:0], reorder(16'h005A, 8, 0) & 16'hFF);
        rd(1, v); chk("R6 collision flag", v, 16'h00C0);
        rd(2, v); chk("R6 rx of original transfer", v, reorder(16'h0055, 8, 0));
        rd(1, v); chk("R8 collision cleared", v, 16'h0000);

        // Overrun (R7) and its clearing (R8)
        launch(16'h0011, 16'h0096);
        settle();
        launch(16'h0022, 16'h0069);
        settle();
        rd(1, v); chk("R7 overrun flag", v, 16'h00A0);
        rd(2, v); chk("R7 buffer keeps first word", v, reorder(16'h0096, 8, 0));
        rd(1, v); chk("R8 overrun cleared", v, 16'h0000);

        // 16-bit, LSB-first, phase 1, polarity 1; divider evened (R2, R3, R11)
        wr(3, 16'h000B);
        rd(3, v); chk("R11 odd divider rounded", v, 16'h000A);
        wr(0, 16'h001F);
        chk("R3 idle sck follows polarity", sck, 1);
        launch(16'hC3A1, 16'h1234);
        settle();
        nb = 16; lsb = 1;
        chk("R3 mosi lsb phase1 16b", c_pat, reorder(16'hC3A1, nb, lsb));
        chk("R3 mosi bit count 16", c_k, 16);
        rd(1, v); chk("R4 done 16b", v, 16'h0080);
        rd(2, v); chk("R4 rx lsb 16b", v, reorder(16'h1234, nb, lsb));

        // 8-bit phase 1, divider clamp, upper bits zero (R4, R11)
        wr(3, 16'h0003);
        rd(3, v); chk("R11 divider floor", v, 16'h0008);
        wr(0, 16'h0014);
        launch(16'h00E7, 16'h00B2);
        settle();
        chk("R3 mosi phase1 8b", c_pat[7:0], reorder(16'h00E7, 8, 0) & 16'hFF);
        rd(1, v); chk("R4 done 8b phase1", v, 16'h0080);
        rd(2, v); chk("R4 8-bit upper zero", v, reorder(16'h00B2, 8, 0));

        // Abort flag (R9)
        @(negedge clk); tst_abort = 1; @(negedge clk); tst_abort = 0;
        @(negedge clk);
        chk("R12 irq with abort", irq, 1);
        rd(1, v); chk("R9 abort set", v, 16'h0008);
        rd(1, v); chk("R9 abort cleared by read", v, 16'h0000);

        // Fault flag (R10) and irq disabled (R12)
        wr(0, 16'h0004);
        @(negedge clk); tst_modef = 1; @(negedge clk); tst_modef = 0;
        @(negedge clk);
        chk("R12 irq disabled", irq, 0);
        rd(1, v); chk("R10 fault set", v, 16'h0010);
        rd(2, v);
        rd(1, v); chk("R10 data access keeps fault", v, 16'h0010);
        wr(0, 16'h0004);
        rd(1, v); chk("R10 fault cleared by ctrl write", v, 16'h0000);

        repeat (4) @(negedge clk);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule